// File: doc/BRIEF.md
# Scanning Serial Line Switch

This block shares two modem-side serial ports, A and B, among eight terminal-side serial ports. Each modem-side port owns a free-running 3-bit scanner. While its port is idle, the scanner steps through the terminal ports one position per scan tick, looking for a terminal that wants a connection. When it finds one, it freezes and connects that terminal to its modem port. The connection carries transmit data and the request lines toward the modem, and carries receive data and the modem status lines back to the terminal. It lasts as long as the terminal keeps its terminal-ready line asserted.

A terminal picks its modem port with its request-to-send line: asserted asks for A, deasserted asks for B. An interlock stops an idle scanner from taking a terminal that the other port already holds. Each modem port also drives a display of the connected port number, from 1 to 8. All routing uses multiplexers, and every signal is active high.

Top module: `scan_line_switch`

## Requirements
- R1: A synchronous reset clears both connections and sets both scanner pointers to 0. After reset every output is at its idle level and both displays are off.
- R2: An idle scanner advances its pointer by one (modulo 8) on each clock with `scan_tick` high. It holds its pointer when `scan_tick` is low. Nothing latches, releases or advances without `scan_tick`.
- R3: Pointer value p (1 to 7) selects terminal port p, which is bit index p-1 of the terminal buses. Pointer value 0 selects port 8 (bit index 7).
- R4: On a tick, idle output A connects when its selected port has DTR=1 and RTS=1. Idle output B connects when its selected port has DTR=1 and RTS=0. A connected scanner's pointer does not move.
- R5: While connected, the chosen port's TXD and RTS appear on the modem side in the same cycle. Its DTR is forwarded through one register, so modem DTR rises one clock after the connection is made.
- R6: While connected, the modem port's RXD, DSR, CTS and CD are returned to the chosen terminal port only.
- R7: A connection survives RTS changes while the chosen port's DTR stays 1. On a tick with that DTR at 0 it is released. Scanning then resumes from the held pointer, with the next tick advancing it.
- R8: An idle scanner whose pointer equals the pointer of the other, connected scanner does not connect, even when that port shows a request. It keeps scanning instead.
- R9: Idle levels: an unconnected modem port drives TXD=1, DTR=0, RTS=0. An unconnected terminal port receives RXD=1, DSR=0, CTS=0, CD=0.
- R10: A display is on while its port is connected and shows the port number 1 to 8. It is off with number 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_tick | input | 1 | Scan step enable (nominally around 30 kHz) |
| term_txd | input | 8 | Transmit data from terminal ports (bit i = port i+1) |
| term_dtr | input | 8 | Terminal ready from terminal ports |
| term_rts | input | 8 | Request to send from terminal ports; selects A (1) or B (0) |
| term_rxd | output | 8 | Receive data to terminal ports |
| term_dsr | output | 8 | Data set ready to terminal ports |
| term_cts | output | 8 | Clear to send to terminal ports |
| term_cd | output | 8 | Carrier detect to terminal ports |
| mdm_a_rxd | input | 1 | Receive data from modem port A |
| mdm_a_dsr | input | 1 | Data set ready from modem port A |
| mdm_a_cts | input | 1 | Clear to send from modem port A |
| mdm_a_cd | input | 1 | Carrier detect from modem port A |
| mdm_b_rxd | input | 1 | Receive data from modem port B |
| mdm_b_dsr | input | 1 | Data set ready from modem port B |
| mdm_b_cts | input | 1 | Clear to send from modem port B |
| mdm_b_cd | input | 1 | Carrier detect from modem port B |
| mdm_a_txd | output | 1 | Transmit data to modem port A |
| mdm_a_dtr | output | 1 | Terminal ready to modem port A |
| mdm_a_rts | output | 1 | Request to send to modem port A |
| mdm_b_txd | output | 1 | Transmit data to modem port B |
| mdm_b_dtr | output | 1 | Terminal ready to modem port B |
| mdm_b_rts | output | 1 | Request to send to modem port B |
| a_disp_on | output | 1 | Display A enable |
| a_disp_num | output | 4 | Display A port number |
| b_disp_on | output | 1 | Display B enable |
| b_disp_num | output | 4 | Display B port number |

## Verification
Two functions can fall in the same clock. In one case, scanner B steps onto a port held by A while that port shows a valid request for B. In the other, one connection is released while the other scanner keeps running. The bench provokes the first by having a port connected to A drop RTS while keeping DTR, so B's sweep passes over a live request for B. It provokes the second by letting DTR fall while the tick is held low and then restoring the tick. A cycle model in the bench, built only from the requirements, predicts every output in every cycle. It judges whether B stays idle and whether the release and resumed sweep happen on the right tick.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    parameter int LSW_PORTS = 8;

    // Lines carried from a terminal port toward a modem port
    typedef struct packed {
        logic txd;
        logic dtr;
        logic rts;
    } fwd_t;

    // Lines carried from a modem port back to a terminal port
    typedef struct packed {
        logic rxd;
        logic dsr;
        logic cts;
        logic cd;
    } ret_t;

    localparam fwd_t FWD_IDLE = '{txd: 1'b1, dtr: 1'b0, rts: 1'b0};
    localparam ret_t RET_IDLE = '{rxd: 1'b1, dsr: 1'b0, cts: 1'b0, cd: 1'b0};

    typedef enum logic {SIDE_A, SIDE_B} side_e;

    // Connection request test: A wants RTS high, B wants RTS low
    function automatic logic wants_side(side_e s, logic dtr, logic rts);
        return dtr && ((s == SIDE_A) ? rts : !rts);
    endfunction

endpackage

// File: rtl/lsw_scanner.sv
module lsw_scanner
    import lsw_pkg::*;
#(
    parameter int    N    = LSW_PORTS,
    parameter side_e SIDE = SIDE_A,
    parameter int    W    = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [N-1:0] dtr,
    input  logic [N-1:0] rts,
    input  logic         blocked,
    output logic [W-1:0] ptr,
    output logic         busy,
    output logic [W-1:0] idx
);

    logic req;

    // Pointer 0 wraps to the last port, p selects port p
    assign idx = ptr - W'(1);
    assign req = wants_side(SIDE, dtr[idx], rts[idx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            busy <= 1'b0;
        end else if (tick) begin
            if (busy) begin
                if (!dtr[idx]) busy <= 1'b0;
            end else if (req && !blocked) begin
                busy <= 1'b1;
            end else begin
                ptr <= ptr + W'(1);
            end
        end
    end

endmodule

// File: rtl/lsw_fwd_path.sv
module lsw_fwd_path
    import lsw_pkg::*;
#(
    parameter int N = LSW_PORTS,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         busy,
    input  logic [W-1:0] idx,
    input  logic [N-1:0] txd,
    input  logic [N-1:0] dtr,
    input  logic [N-1:0] rts,
    output fwd_t         fwd
);

    logic dtr_q;

    // Terminal ready goes out one stage after the other lines
    always_ff @(posedge clk) begin
        if (rst) dtr_q <= 1'b0;
        else     dtr_q <= busy && dtr[idx];
    end

    always_comb begin
        fwd = FWD_IDLE;
        if (busy) begin
            fwd.txd = txd[idx];
            fwd.rts = rts[idx];
        end
        fwd.dtr = dtr_q;
    end

endmodule

// File: rtl/lsw_ret_path.sv
module lsw_ret_path
    import lsw_pkg::*;
#(
    parameter int N = LSW_PORTS,
    parameter int W = $clog2(N)
) (
    input  logic         busy_a,
    input  logic [W-1:0] idx_a,
    input  ret_t         ret_a,
    input  logic         busy_b,
    input  logic [W-1:0] idx_b,
    input  ret_t         ret_b,
    output logic [N-1:0] rxd,
    output logic [N-1:0] dsr,
    output logic [N-1:0] cts,
    output logic [N-1:0] cd
);

    for (genvar i = 0; i < N; i++) begin : g_port
        ret_t sel_r;
        always_comb begin
            if (busy_a && (idx_a == W'(i)))      sel_r = ret_a;
            else if (busy_b && (idx_b == W'(i))) sel_r = ret_b;
            else                                 sel_r = RET_IDLE;
        end
        assign rxd[i] = sel_r.rxd;
        assign dsr[i] = sel_r.dsr;
        assign cts[i] = sel_r.cts;
        assign cd[i]  = sel_r.cd;
    end

endmodule

// File: rtl/scan_line_switch.sv
module scan_line_switch
    import lsw_pkg::*;
#(
    parameter int N_PORTS = LSW_PORTS,
    parameter int PW      = $clog2(N_PORTS),
    parameter int DW      = PW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scan_tick,
    input  logic [N_PORTS-1:0] term_txd,
    input  logic [N_PORTS-1:0] term_dtr,
    input  logic [N_PORTS-1:0] term_rts,
    output logic [N_PORTS-1:0] term_rxd,
    output logic [N_PORTS-1:0] term_dsr,
    output logic [N_PORTS-1:0] term_cts,
    output logic [N_PORTS-1:0] term_cd,
    input  logic               mdm_a_rxd,
    input  logic               mdm_a_dsr,
    input  logic               mdm_a_cts,
    input  logic               mdm_a_cd,
    input  logic               mdm_b_rxd,
    input  logic               mdm_b_dsr,
    input  logic               mdm_b_cts,
    input  logic               mdm_b_cd,
    output logic               mdm_a_txd,
    output logic               mdm_a_dtr,
    output logic               mdm_a_rts,
    output logic               mdm_b_txd,
    output logic               mdm_b_dtr,
    output logic               mdm_b_rts,
    output logic               a_disp_on,
    output logic [DW-1:0]      a_disp_num,
    output logic               b_disp_on,
    output logic [DW-1:0]      b_disp_num
);

    logic [PW-1:0] ptr_a, ptr_b, idx_a, idx_b;
    logic          busy_a, busy_b;
    logic          blk_a, blk_b;
    fwd_t          fwd_a, fwd_b;
    ret_t          ret_a, ret_b;

    // Interlock: a port held by one side is closed to the other
    assign blk_a = busy_b && (ptr_b == ptr_a);
    assign blk_b = busy_a && (ptr_a == ptr_b);

    lsw_scanner #(.N(N_PORTS), .SIDE(SIDE_A)) u_scan_a (
        .clk(clk), .rst(rst), .tick(scan_tick),
        .dtr(term_dtr), .rts(term_rts), .blocked(blk_a),
        .ptr(ptr_a), .busy(busy_a), .idx(idx_a)
    );

    lsw_scanner #(.N(N_PORTS), .SIDE(SIDE_B)) u_scan_b (
        .clk(clk), .rst(rst), .tick(scan_tick),
        .dtr(term_dtr), .rts(term_rts), .blocked(blk_b),
        .ptr(ptr_b), .busy(busy_b), .idx(idx_b)
    );

    lsw_fwd_path #(.N(N_PORTS)) u_fwd_a (
        .clk(clk), .rst(rst), .busy(busy_a), .idx(idx_a),
        .txd(term_txd), .dtr(term_dtr), .rts(term_rts), .fwd(fwd_a)
    );

    lsw_fwd_path #(.N(N_PORTS)) u_fwd_b (
        .clk(clk), .rst(rst), .busy(busy_b), .idx(idx_b),
        .txd(term_txd), .dtr(term_dtr), .rts(term_rts), .fwd(fwd_b)
    );

    assign ret_a = '{rxd: mdm_a_rxd, dsr: mdm_a_dsr, cts: mdm_a_cts, cd: mdm_a_cd};
    assign ret_b = '{rxd: mdm_b_rxd, dsr: mdm_b_dsr, cts: mdm_b_cts, cd: mdm_b_cd};

    lsw_ret_path #(.N(N_PORTS)) u_ret (
        .busy_a(busy_a), .idx_a(idx_a), .ret_a(ret_a),
        .busy_b(busy_b), .idx_b(idx_b), .ret_b(ret_b),
        .rxd(term_rxd), .dsr(term_dsr), .cts(term_cts), .cd(term_cd)
    );

    assign mdm_a_txd = fwd_a.txd;
    assign mdm_a_dtr = fwd_a.dtr;
    assign mdm_a_rts = fwd_a.rts;
    assign mdm_b_txd = fwd_b.txd;
    assign mdm_b_dtr = fwd_b.dtr;
    assign mdm_b_rts = fwd_b.rts;

    // Display numbering runs 1..N, pointer 0 shows N
    assign a_disp_on  = busy_a;
    assign b_disp_on  = busy_b;
    assign a_disp_num = !busy_a ? '0 : (ptr_a == '0) ? DW'(N_PORTS) : DW'(ptr_a);
    assign b_disp_num = !busy_b ? '0 : (ptr_b == '0) ? DW'(N_PORTS) : DW'(ptr_b);

endmodule

// File: rtl/lsw_chk.sv
module lsw_chk #(
    parameter int N  = 8,
    parameter int PW = $clog2(N),
    parameter int DW = PW + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          busy_a,
    input logic          busy_b,
    input logic [PW-1:0] ptr_a,
    input logic [PW-1:0] ptr_b,
    input logic          a_txd,
    input logic          a_dtr,
    input logic          a_rts,
    input logic          a_on,
    input logic [DW-1:0] a_num
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy_a && !busy_b && ptr_a == '0 && ptr_b == '0));

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_a && !tick) |=> (ptr_a == $past(ptr_a)));

    // R4
    frozen_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        busy_a |=> (ptr_a == $past(ptr_a)));

    // R5
    dtr_late_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(a_dtr) |-> $past(busy_a));

    // R8
    no_double_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy_a && busy_b && ptr_a == ptr_b));

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_a |-> (a_txd && !a_dtr && !a_rts));

    // R10
    disp_range_chk: assert property (@(posedge clk) disable iff (rst)
        a_on |-> (a_num != '0 && a_num <= DW'(N)));

    // R10
    disp_off_chk: assert property (@(posedge clk) disable iff (rst)
        !a_on |-> (a_num == '0));

endmodule

bind scan_line_switch lsw_chk #(.N(N_PORTS)) u_chk (
    .clk(clk), .rst(rst), .tick(scan_tick),
    .busy_a(busy_a), .busy_b(busy_b), .ptr_a(ptr_a), .ptr_b(ptr_b),
    .a_txd(mdm_a_txd), .a_dtr(mdm_a_dtr), .a_rts(mdm_a_rts),
    .a_on(a_disp_on), .a_num(a_disp_num)
);

// File: tb/tb_scan_line_switch.sv
`timescale 1ns/1ps
module tb_scan_line_switch;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_tick = 1'b1;
    logic [7:0] term_txd = 8'hFF, term_dtr = 8'h00, term_rts = 8'h00;
    logic [7:0] term_rxd, term_dsr, term_cts, term_cd;
    logic       a_rxd = 1'b1, a_dsr = 1'b0, a_cts = 1'b0, a_cd = 1'b0;
    logic       b_rxd = 1'b1, b_dsr = 1'b0, b_cts = 1'b0, b_cd = 1'b0;
    logic       a_txd, a_dtr, a_rts, b_txd, b_dtr, b_rts;
    logic       a_on, b_on;
    logic [3:0] a_num, b_num;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    scan_line_switch dut (
        .clk(clk), .rst(rst), .scan_tick(scan_tick),
        .term_txd(term_txd), .term_dtr(term_dtr), .term_rts(term_rts),
        .term_rxd(term_rxd), .term_dsr(term_dsr), .term_cts(term_cts), .term_cd(term_cd),
        .mdm_a_rxd(a_rxd), .mdm_a_dsr(a_dsr), .mdm_a_cts(a_cts), .mdm_a_cd(a_cd),
        .mdm_b_rxd(b_rxd), .mdm_b_dsr(b_dsr), .mdm_b_cts(b_cts), .mdm_b_cd(b_cd),
        .mdm_a_txd(a_txd), .mdm_a_dtr(a_dtr), .mdm_a_rts(a_rts),
        .mdm_b_txd(b_txd), .mdm_b_dtr(b_dtr), .mdm_b_rts(b_rts),
        .a_disp_on(a_on), .a_disp_num(a_num), .b_disp_on(b_on), .b_disp_num(b_num)
    );

    typedef struct {
        string       tag;
        logic [4:0]  disp_a;
        logic [4:0]  disp_b;
        logic [2:0]  fwd_a;
        logic [2:0]  fwd_b;
        logic [7:0]  rxd;
        logic [23:0] stat;
    } exp_t;

    exp_t q[$];

    // Reference state built from the requirements
    logic [2:0] m_pa = 3'd0, m_pb = 3'd0;
    logic       m_ba = 1'b0, m_bb = 1'b0, m_da = 1'b0, m_db = 1'b0;

    task automatic model_update();
        logic [2:0] ia, ib, npa, npb;
        logic       nba, nbb;
        ia = m_pa - 3'd1;
        ib = m_pb - 3'd1;
        if (rst) begin
            m_pa = 0; m_pb = 0; m_ba = 0; m_bb = 0; m_da = 0; m_db = 0;
            return;
        end
        npa = m_pa; npb = m_pb; nba = m_ba; nbb = m_bb;
        if (scan_tick) begin
            if (m_ba) begin
                if (!term_dtr[ia]) nba = 1'b0;
            end else if (term_dtr[ia] && term_rts[ia] && !(m_bb && m_pb == m_pa)) nba = 1'b1;
            else npa = m_pa + 3'd1;
            if (m_bb) begin
                if (!term_dtr[ib]) nbb = 1'b0;
            end else if (term_dtr[ib] && !term_rts[ib] && !(m_ba && m_pa == m_pb)) nbb = 1'b1;
            else npb = m_pb + 3'd1;
        end
        m_da = m_ba && term_dtr[ia];
        m_db = m_bb && term_dtr[ib];
        m_pa = npa; m_pb = npb; m_ba = nba; m_bb = nbb;
    endtask

    function automatic logic [3:0] pnum(logic on, logic [2:0] p);
        if (!on) return 4'd0;
        return (p == 3'd0) ? 4'd8 : {1'b0, p};
    endfunction

    task automatic push_expect(input string tag);
        exp_t e;
        logic [2:0] ia, ib;
        ia = m_pa - 3'd1;
        ib = m_pb - 3'd1;
        e.tag    = tag;
        e.disp_a = {m_ba, pnum(m_ba, m_pa)};
        e.disp_b = {m_bb, pnum(m_bb, m_pb)};
        e.fwd_a  = m_ba ? {term_txd[ia], m_da, term_rts[ia]} : {1'b1, m_da, 1'b0};
        e.fwd_b  = m_bb ? {term_txd[ib], m_db, term_rts[ib]} : {1'b1, m_db, 1'b0};
        for (int i = 0; i < 8; i++) begin
            logic [3:0] r;
            r = 4'b1000;
            if (m_ba && ia == 3'(i))      r = {a_rxd, a_dsr, a_cts, a_cd};
            else if (m_bb && ib == 3'(i)) r = {b_rxd, b_dsr, b_cts, b_cd};
            e.rxd[i]       = r[3];
            e.stat[i]      = r[2];
            e.stat[8 + i]  = r[1];
            e.stat[16 + i] = r[0];
        end
        q.push_back(e);
    endtask

    task automatic cmp(input string tag, input string what, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Monitor: compare design outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "display A", 24'({a_on, a_num}), 24'(e.disp_a));
                cmp(e.tag, "display B", 24'({b_on, b_num}), 24'(e.disp_b));
                cmp(e.tag, "modem A out", 24'({a_txd, a_dtr, a_rts}), 24'(e.fwd_a));
                cmp(e.tag, "modem B out", 24'({b_txd, b_dtr, b_rts}), 24'(e.fwd_b));
                cmp(e.tag, "term rxd", 24'(term_rxd), 24'(e.rxd));
                cmp(e.tag, "term status", {term_cd, term_cts, term_dsr}, e.stat);
            end
        end
    end

    task automatic step(input string tag);
        @(posedge clk);
        model_update();
        push_expect(tag);
        @(negedge clk);
        #1;
    endtask

    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    initial begin
        #1;
        // R1: reset state
        run(3, "R1");
        rst = 1'b0;
        // R9: idle levels while nobody asks
        run(4, "R9");
        // R2: tick gating on the idle sweep
        for (int k = 0; k < 10; k++) begin
            scan_tick = k[0];
            step("R2");
        end
        scan_tick = 1'b1;
        // R4 and R3: port 3 asks for A
        term_dtr[2] = 1'b1; term_rts[2] = 1'b1;
        run(12, "R4");
        // R5: data and RTS follow the port
        for (int k = 0; k < 6; k++) begin
            term_txd[2] = k[0];
            step("R5");
        end
        // R6: modem A status reaches port 3 only
        a_rxd = 1'b0; a_dsr = 1'b1; a_cts = 1'b1; a_cd = 1'b1;
        b_rxd = 1'b0; b_dsr = 1'b1; b_cts = 1'b0; b_cd = 1'b1;
        run(3, "R6");
        a_cts = 1'b0;
        run(2, "R6");
        // R7 and R8: port 3 drops RTS, keeps DTR; B sweeps past it
        term_rts[2] = 1'b0;
        run(20, "R8");
        // R3: port 8 asks for B, pointer 0
        term_dtr[7] = 1'b1;
        run(10, "R3");
        // R7: port 3 releases A, sweep resumes
        term_dtr[2] = 1'b0;
        run(3, "R7");
        term_dtr[4] = 1'b1; term_rts[4] = 1'b1;
        run(10, "R4");
        // R2 and R7: DTR falls while tick held low, then tick returns
        scan_tick = 1'b0;
        term_dtr[7] = 1'b0;
        run(3, "R2");
        scan_tick = 1'b1;
        run(4, "R7");
        // R10: release A, then long idle sweep and a port 1 request for B
        term_dtr[4] = 1'b0;
        run(3, "R10");
        for (int k = 0; k < 20; k++) begin
            scan_tick = (k % 3) != 0;
            step("R2");
        end
        scan_tick = 1'b1;
        term_dtr[0] = 1'b1; term_rts[0] = 1'b0;
        run(12, "R10");
        // R1: reset during a live connection
        rst = 1'b1;
        run(2, "R1");
        rst = 1'b0;
        term_dtr = 8'h00;
        run(3, "R9");
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule